// File: doc/BRIEF.md
# Two-Lane Negated Multiply-Add Retirement Controller

This block sits at the tail of a two-lane, double-precision negated multiply-add vector operation. The arithmetic stage upstream has already formed and rounded a×b+c for each 64-bit lane. The addend c is taken from the destination register itself. For each lane, the arithmetic stage hands this block the rounded value and the six exception indications it raised. The block negates each lane after rounding and accumulates the indications into a sticky status register with a summary bit. It then weighs the indications against the per-class trap enables and decides whether the 128-bit destination may be written.

The operation is all-or-nothing. An enabled exception in either lane blocks the write of both lanes. If the vector facility is disabled, the operation raises a one-cycle unavailable trap and touches neither the destination nor the status. The two-bit rounding mode is carried straight through to the external rounding stage.

Top module: `vfma_retire`

## Requirements
- R1: After reset, wr_en_o, trap_o and done_o are 0, wr_data_o is 0 and status_o is 0.
- R2: A lane result that is not a NaN is delivered with bit 63 inverted and bits 62:0 unchanged. Lane 0 occupies wr_data_o[63:0] and lane 1 occupies wr_data_o[127:64].
- R3: A NaN lane result passes through unchanged, sign included. A NaN is an exponent field [62:52] of all ones with a nonzero fraction [51:0]; an infinity (zero fraction) is negated.
- R4: Flag bit positions are 0 signalling-NaN invalid, 1 inf×zero invalid, 2 inf−inf invalid, 3 overflow, 4 underflow and 5 inexact. For each accepted operation with the facility enabled, status_o[5:0] gains the OR of both lanes' flags. Status bits are never cleared, except by reset.
- R5: status_o[6] (summary) becomes 1 on any operation that reports at least one flag, and stays 1.
- R6: Enable bit 0 arms all three invalid classes, bit 1 arms overflow, bit 2 arms underflow and bit 3 arms inexact. If any flag of either lane is armed, wr_en_o stays 0 for that operation.
- R7: If no flag of either lane is armed, wr_en_o pulses 1 with both negated lanes, even when unarmed flags are present.
- R8: An accepted operation with vec_en_i low pulses trap_o, keeps wr_en_o at 0 and leaves status_o unchanged.
- R9: Results (wr_en_o, trap_o, done_o, and the updated status_o) appear one cycle after the accepted input and last one cycle. in_ready_o is always 1.
- R10: rnd_mode_o equals rnd_mode_i combinationally at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation valid |
| in_ready_o | output | 1 | Always ready |
| vec_en_i | input | 1 | Vector facility enable |
| exc_en_i | input | 4 | Trap enables: invalid, overflow, underflow, inexact |
| rnd_mode_i | input | 2 | Current rounding mode |
| rnd_mode_o | output | 2 | Rounding mode to rounding stage |
| lane0_res_i | input | 64 | Rounded lane 0 result |
| lane1_res_i | input | 64 | Rounded lane 1 result |
| lane0_flags_i | input | 6 | Lane 0 exception flags |
| lane1_flags_i | input | 6 | Lane 1 exception flags |
| wr_en_o | output | 1 | Destination write enable |
| wr_data_o | output | 128 | Destination write data |
| trap_o | output | 1 | Unavailable trap pulse |
| done_o | output | 1 | Operation retired pulse |
| status_o | output | 7 | Sticky status, bit 6 summary |

## Verification
The bench places a NaN next to an infinity and a NaN that has its sign bit set. A design that flips every sign, or treats infinities as NaNs, returns the wrong word. Armed exceptions are raised in only one lane, once from lane 1 alone, so a design that masks per lane, or that looks at lane 0 only, would still write. Unarmed flags are paired with armed enables of other classes, which exposes a wrong enable-to-class mapping. An operation with no flags follows one that set flags, and a disabled-facility operation carries flags, so a status register that clears, or that updates during a trap, shows a changed value.

// File: rtl/vfma_retire_pkg.sv
package vfma_retire_pkg;
  localparam int unsigned NFLAG  = 6;
  localparam int unsigned NEN    = 4;
  localparam int unsigned FX_BIT = NFLAG;
  localparam int unsigned F_SNAN = 0;
  localparam int unsigned F_IMZ  = 1;
  localparam int unsigned F_ISI  = 2;
  localparam int unsigned F_OVF  = 3;
  localparam int unsigned F_UNF  = 4;
  localparam int unsigned F_INX  = 5;
  localparam int unsigned E_INV  = 0;
  localparam int unsigned E_OVF  = 1;
  localparam int unsigned E_UNF  = 2;
  localparam int unsigned E_INX  = 3;
  typedef logic [NFLAG-1:0] flags_t;
  typedef logic [NEN-1:0]   en_t;
  typedef logic [NFLAG:0]   status_t;
endpackage

// File: rtl/vfma_lane_neg.sv
module vfma_lane_neg #(
  parameter int unsigned DW    = 64,
  parameter int unsigned EXP_W = 11
) (
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned FRAC_W = DW - EXP_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              is_nan;

  assign exp_f  = res_i[DW-2 -: EXP_W];
  assign frac_f = res_i[FRAC_W-1:0];
  assign is_nan = (&exp_f) && (|frac_f);

  always_comb begin
    res_o = res_i;
    if (!is_nan) res_o[DW-1] = ~res_i[DW-1];
  end

  // R2/R3: magnitude bits never change
  always_comb begin
    a_mag_kept_r2: assert (res_o[DW-2:0] == res_i[DW-2:0]);
  end
endmodule

// File: rtl/vfma_exc_eval.sv
module vfma_exc_eval
  import vfma_retire_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  flags_t [LANES-1:0] flags_i,
  input  en_t                en_i,
  output flags_t             any_o,
  output logic               trip_o
);
  flags_t armed;

  always_comb begin
    any_o = '0;
    for (int l = 0; l < LANES; l++) any_o |= flags_i[l];
  end

  always_comb begin
    armed         = '0;
    armed[F_SNAN] = en_i[E_INV];
    armed[F_IMZ]  = en_i[E_INV];
    armed[F_ISI]  = en_i[E_INV];
    armed[F_OVF]  = en_i[E_OVF];
    armed[F_UNF]  = en_i[E_UNF];
    armed[F_INX]  = en_i[E_INX];
  end

  assign trip_o = |(any_o & armed);

  always_comb begin
    a_no_trip_no_flags_r6: assert (!(trip_o && any_o == '0));
  end
endmodule

// File: rtl/vfma_status.sv
module vfma_status
  import vfma_retire_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    upd_i,
  input  flags_t  flags_i,
  output status_t status_o
);
  status_t status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (upd_i) begin
      status_q[NFLAG-1:0] <= status_q[NFLAG-1:0] | flags_i;
      if (|flags_i) status_q[FX_BIT] <= 1'b1;
    end
  end

  assign status_o = status_q;

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & $past(status_q)) == $past(status_q)));
  p_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_q[NFLAG-1:0]) |-> status_q[FX_BIT]);
  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(status_q));
endmodule

// File: rtl/vfma_retire.sv
module vfma_retire
  import vfma_retire_pkg::*;
#(
  parameter int unsigned DW    = 64,
  parameter int unsigned EXP_W = 11,
  parameter int unsigned RM_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              vec_en_i,
  input  logic [NEN-1:0]    exc_en_i,
  input  logic [RM_W-1:0]   rnd_mode_i,
  output logic [RM_W-1:0]   rnd_mode_o,
  input  logic [DW-1:0]     lane0_res_i,
  input  logic [DW-1:0]     lane1_res_i,
  input  logic [NFLAG-1:0]  lane0_flags_i,
  input  logic [NFLAG-1:0]  lane1_flags_i,
  output logic              wr_en_o,
  output logic [2*DW-1:0]   wr_data_o,
  output logic              trap_o,
  output logic              done_o,
  output logic [NFLAG:0]    status_o
);
  localparam int unsigned LANES = 2;
  localparam int unsigned VW    = LANES * DW;

  logic [LANES-1:0][DW-1:0] lane_in, lane_neg;
  flags_t [LANES-1:0]       lane_flags;
  flags_t                   any_flags;
  logic                     trip, accept, go;
  logic                     wr_en_q, trap_q, done_q;
  logic [VW-1:0]            wr_data_q;

  assign lane_in[0]    = lane0_res_i;
  assign lane_in[1]    = lane1_res_i;
  assign lane_flags[0] = lane0_flags_i;
  assign lane_flags[1] = lane1_flags_i;

  assign in_ready_o = 1'b1;
  assign rnd_mode_o = rnd_mode_i;
  assign accept     = in_valid_i & in_ready_o;
  assign go         = accept & vec_en_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vfma_lane_neg #(.DW(DW), .EXP_W(EXP_W)) i_neg (
      .res_i (lane_in[g]),
      .res_o (lane_neg[g])
    );
  end

  vfma_exc_eval #(.LANES(LANES)) i_exc (
    .flags_i (lane_flags),
    .en_i    (exc_en_i),
    .any_o   (any_flags),
    .trip_o  (trip)
  );

  vfma_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (go),
    .flags_i  (any_flags),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      trap_q    <= 1'b0;
      done_q    <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= go & ~trip;
      trap_q  <= accept & ~vec_en_i;
      done_q  <= accept;
      if (go) wr_data_q <= lane_neg;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign trap_o    = trap_q;
  assign done_o    = done_q;
  assign wr_data_o = wr_data_q;

  p_trap_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !wr_en_o);
  p_disabled_traps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !vec_en_i) |=> (trap_o && !wr_en_o));
  p_armed_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && |(exc_en_i[E_INV] ? (lane0_flags_i | lane1_flags_i) & 6'h07 : 6'h00))
      |=> !wr_en_o);
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!wr_en_o && !trap_o && !done_o));
  p_out_needs_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(in_valid_i));
endmodule

// File: tb/test_vfma_retire.sv
module test_vfma_retire;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready, vec_en = 1'b0;
  logic [3:0]   exc_en = '0;
  logic [1:0]   rm_i = '0, rm_o;
  logic [63:0]  l0 = '0, l1 = '0;
  logic [5:0]   f0 = '0, f1 = '0;
  logic         wr_en, trap, done;
  logic [127:0] wr_data;
  logic [6:0]   status;

  int total = 0, bad = 0;
  logic [6:0] st_model = '0;

  always #10 clk = ~clk;

  vfma_retire i_vfma_retire (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .vec_en_i(vec_en), .exc_en_i(exc_en), .rnd_mode_i(rm_i), .rnd_mode_o(rm_o),
    .lane0_res_i(l0), .lane1_res_i(l1), .lane0_flags_i(f0), .lane1_flags_i(f1),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .trap_o(trap), .done_o(done),
    .status_o(status)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [5:0]  fa;
    logic [5:0]  fb;
    logic        ven;
    logic [3:0]  en;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{64'h3FF0000000000000, 64'hC000000000000000, 6'h00, 6'h00, 1'b1, 4'h0},
    '{64'h7FF8000000000001, 64'h0000000000000000, 6'h00, 6'h00, 1'b1, 4'hF},
    '{64'h7FF0000000000000, 64'h0000000000000001, 6'h20, 6'h00, 1'b1, 4'h0},
    '{64'h4000000000000000, 64'h7FEFFFFFFFFFFFFF, 6'h00, 6'h08, 1'b1, 4'h2},
    '{64'hFFF8000000000000, 64'h1234567812345678, 6'h01, 6'h00, 1'b1, 4'h1},
    '{64'h3FF0000000000000, 64'h3FF0000000000000, 6'h10, 6'h02, 1'b0, 4'hF},
    '{64'h8000000000000000, 64'h0000000000000000, 6'h00, 6'h10, 1'b1, 4'hB},
    '{64'h0000000000000000, 64'hFFF0000000000000, 6'h00, 6'h00, 1'b1, 4'h0}
  };

  function automatic logic [63:0] neg_model(input logic [63:0] v);
    if (&v[62:52] && |v[51:0]) return v;
    return {~v[63], v[62:0]};
  endfunction

  function automatic logic [5:0] armed_model(input logic [3:0] e);
    return {e[3], e[2], e[1], e[0], e[0], e[0]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    logic [5:0] any;
    logic exp_wr;
    @(negedge clk);
    l0 = v.a; l1 = v.b; f0 = v.fa; f1 = v.fb; vec_en = v.ven; exc_en = v.en;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    any = v.fa | v.fb;
    exp_wr = v.ven && ((any & armed_model(v.en)) == 6'h00);
    if (v.ven) begin
      st_model[5:0] = st_model[5:0] | any;
      if (|any) st_model[6] = 1'b1;
    end
    chk(wr_en == exp_wr, "R6/R7 wr_en", {127'd0, wr_en}, {127'd0, exp_wr});
    chk(trap == !v.ven, "R8 trap", {127'd0, trap}, {127'd0, !v.ven});
    chk(done == 1'b1, "R9 done", {127'd0, done}, 128'd1);
    chk(status == st_model, "R4/R5 status", {121'd0, status}, {121'd0, st_model});
    if (exp_wr)
      chk(wr_data == {neg_model(v.b), neg_model(v.a)}, "R2/R3 data", wr_data,
          {neg_model(v.b), neg_model(v.a)});
  endtask

  task automatic finish_all;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_all();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_en && !trap && !done, "R1 ctrl", {125'd0, wr_en, trap, done}, 128'd0);
    chk(wr_data == '0 && status == '0, "R1 data/status", {wr_data[63:0], 57'd0, status}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready", {127'd0, in_ready}, 128'd1);
    for (int i = 0; i < NV; i++) run_op(TBL[i]);
    // R4 sticky: no-flag op keeps bits
    run_op('{64'h1, 64'h2, 6'h00, 6'h00, 1'b1, 4'h0});
    chk(status[5] && status[3] && status[0] && status[6], "R4 sticky",
        {121'd0, status}, {121'd0, st_model});
    // R9: idle cycle gives no pulses
    @(negedge clk);
    chk(!wr_en && !trap && !done, "R9 pulse", {125'd0, wr_en, trap, done}, 128'd0);
    // R3 NaN with sign set alongside negative infinity
    run_op('{64'hFFF0000000000001, 64'hFFF0000000000000, 6'h00, 6'h00, 1'b1, 4'h0});
    chk(wr_data == {64'h7FF0000000000000, 64'hFFF0000000000001}, "R3 nan",
        wr_data, {64'h7FF0000000000000, 64'hFFF0000000000001});
    // R10 rounding mode passthrough
    for (int m = 0; m < 4; m++) begin
      rm_i = 2'(m);
      #1;
      chk(rm_o == 2'(m), "R10 rnd", {126'd0, rm_o}, 128'(m));
    end
    finish_all();
  end
endmodule